// File: doc/BRIEF.md
# Machine-Level Trap and Privilege Controller

This block keeps the machine-level trap state of a small 32-bit hart and carries out trap entry and trap return for the core. It holds a status word, with the global interrupt enable, the saved enable and the saved privilege level, and six more registers: an interrupt enable mask, a read-only view of the pending interrupt lines, a trap vector, an exception PC, a cause word and a scratch word. It also holds the current privilege level. The core reaches these registers through a CSR port that supports read, write, set and clear. The core raises synchronous exceptions with a cause code and a PC, feeds in raw interrupt lines, and strobes a return request. In the same cycle the block answers with a trap-taken or return-taken flag and the PC to redirect to.

The privilege level is the state machine of the block. It has three states: `PRIV_M` (11), `PRIV_S` (01) and `PRIV_U` (00). There are two transitions. TRAP_ENTRY goes from any state to `PRIV_M` whenever a trap is taken. TRAP_RETURN goes from `PRIV_M` to the level held in the saved-level field whenever a return is accepted. Every register update for an entry or a return happens on the single clock edge that ends the request cycle.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the level is machine (11). Every register reads zero: status, enable mask, vector, exception PC, cause and scratch.
- R2: CSR op codes are 00 read, 01 write, 10 set and 11 clear. `csr_rdata_o` always shows the value before the update. The new value is stored on the clock edge. Set ORs the write data into the register, and clear removes the set bits with AND-NOT. Addresses: status 0x300, enable mask 0x304, vector 0x305, scratch 0x340, exception PC 0x341, cause 0x342, pending 0x344. Any other address reads zero and accepts no write.
- R3: When a trap is taken, `trap_taken_o` is 1 in the request cycle. On the next edge the following updates happen: the saved enable (status bit 7) takes the global enable (bit 3), the global enable is cleared, the saved level (bits 12:11) takes the old level, the level becomes machine, and the exception PC takes `trap_pc_i` with bits 1:0 forced to zero.
- R4: The cause word has bit 31 = 1 and the line number in bits 3:0 for an interrupt. It has bit 31 = 0 and `exc_code_i` in bits 3:0 for an exception.
- R5: Interrupt line n is eligible only when pending line n and mask bit n are both 1. At machine level the global enable must also be 1. Below machine level the global enable is ignored.
- R6: When several interrupt lines are eligible, the line with the highest number is taken.
- R7: The handler base is the vector with bits 1:0 cleared. When vector bits 1:0 are 00, every trap goes to the base. When they are nonzero, an interrupt goes to base + 4 × line number, and an exception still goes to the base.
- R8: A return request is accepted only at machine level, and then `ret_taken_o` is 1 and the redirect is the exception PC. On the next edge the global enable takes the saved enable, the saved enable becomes 1, the saved level becomes user (00), and the level becomes the old saved level. A return request below machine level is ignored.
- R9: An exception wins over interrupts in the same cycle. A taken trap cancels a return request and a CSR write that arrive in the same cycle.
- R10: The pending register mirrors the interrupt lines and ignores writes. A write of 10 to the saved-level field leaves that field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 4 | Exception cause code |
| trap_pc_i | input | 32 | PC to save if a trap is taken this cycle |
| irq_lines_i | input | 16 | Raw interrupt lines, one per cause code |
| mret_i | input | 1 | Trap return request |
| csr_en_i | input | 1 | CSR access strobe |
| csr_op_i | input | 2 | CSR operation (00 read, 01 write, 10 set, 11 clear) |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write or mask data |
| csr_rdata_o | output | 32 | Value of the addressed register before the update |
| trap_taken_o | output | 1 | A trap is taken this cycle |
| ret_taken_o | output | 1 | A return is accepted this cycle |
| redirect_pc_o | output | 32 | Handler address on a trap, exception PC on a return |
| priv_o | output | 2 | Current privilege level |

## Verification
Three functions can fall in the same cycle: an exception, an interrupt, and a return request or CSR write. The bench provokes this by raising an exception, two eligible interrupt lines, a return request and a scratch write on the same clock. It then checks four results: the redirect goes to the exception base, the cause is the exception code, the scratch word and the level are unchanged by the cancelled requests, and the saved fields hold the trap values. After that the bench re-enables interrupts while both lines are still high, and checks that the higher line wins with the vectored offset.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        CSR_READ  = 2'b00,
        CSR_WRITE = 2'b01,
        CSR_SET   = 2'b10,
        CSR_CLEAR = 2'b11
    } csr_op_e;

    localparam logic [11:0] ADDR_STATUS  = 12'h300;
    localparam logic [11:0] ADDR_IRQEN   = 12'h304;
    localparam logic [11:0] ADDR_VECTOR  = 12'h305;
    localparam logic [11:0] ADDR_SCRATCH = 12'h340;
    localparam logic [11:0] ADDR_EPC     = 12'h341;
    localparam logic [11:0] ADDR_CAUSE   = 12'h342;
    localparam logic [11:0] ADDR_PEND    = 12'h344;

    localparam int BIT_GIE = 3;
    localparam int BIT_PIE = 7;
    localparam int BIT_PPL = 11;
endpackage

// File: rtl/trap_irq_arb.sv
module trap_irq_arb #(
    parameter int NIRQ  = 16,
    parameter int CODEW = $clog2(NIRQ)
) (
    input  logic [NIRQ-1:0]  pend_i,
    input  logic [NIRQ-1:0]  en_i,
    input  logic             gate_i,
    output logic             fire_o,
    output logic [CODEW-1:0] code_o
);
    logic [NIRQ-1:0] live;

    assign live   = pend_i & en_i;
    assign fire_o = gate_i & (|live);

    // Highest numbered eligible line wins: later iterations overwrite.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < NIRQ; i++) begin
            if (live[i]) code_o = CODEW'(i);
        end
    end

    always_comb begin
        if (fire_o) begin
            p_winner_live_r6: assert (pend_i[code_o] && en_i[code_o]);
        end
    end
endmodule

// File: rtl/trap_priv_fsm.sv
module trap_priv_fsm
    import trap_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  trap_go_i,
    input  logic  ret_go_i,
    input  priv_e ret_lvl_i,
    output priv_e priv_o
);
    priv_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= PRIV_M;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PRIV_M: begin
                if (trap_go_i)     state_d = PRIV_M;
                else if (ret_go_i) state_d = ret_lvl_i;
            end
            PRIV_S, PRIV_U: begin
                if (trap_go_i) state_d = PRIV_M;
            end
            default: state_d = PRIV_M;
        endcase
    end

    assign priv_o = state_q;

    p_trap_enters_m_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_go_i |=> (state_q == PRIV_M));
    p_ret_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_go_i |=> (state_q == $past(ret_lvl_i)));
    p_ret_only_in_m_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_go_i |-> (state_q == PRIV_M));
    always_comb begin
        p_legal_level_r10: assert (!rst_ni || state_q != 2'b10);
    end
endmodule

// File: rtl/trap_csr_regs.sv
module trap_csr_regs
    import trap_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NIRQ  = 16,
    parameter int CODEW = $clog2(NIRQ)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             csr_en_i,
    input  logic [1:0]       csr_op_i,
    input  logic [11:0]      csr_addr_i,
    input  logic [XLEN-1:0]  csr_wdata_i,
    output logic [XLEN-1:0]  csr_rdata_o,
    input  logic             trap_go_i,
    input  logic             trap_irq_i,
    input  logic [CODEW-1:0] trap_code_i,
    input  logic [XLEN-1:0]  trap_pc_i,
    input  logic             ret_go_i,
    input  priv_e            cur_priv_i,
    input  logic [NIRQ-1:0]  irq_lines_i,
    output logic             gie_o,
    output priv_e            ppl_o,
    output logic [NIRQ-1:0]  irq_en_o,
    output logic [XLEN-1:0]  vec_o,
    output logic [XLEN-1:0]  epc_o
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    logic             gie_q, pie_q;
    priv_e            ppl_q;
    logic [NIRQ-1:0]  en_q;
    logic [XLEN-1:0]  vec_q, epc_q, scratch_q;
    logic             cause_irq_q;
    logic [CODEW-1:0] cause_code_q;
    logic [XLEN-1:0]  rd, nv;
    logic             wr;

    always_comb begin
        rd = '0;
        unique case (csr_addr_i)
            ADDR_STATUS: begin
                rd[BIT_GIE]           = gie_q;
                rd[BIT_PIE]           = pie_q;
                rd[BIT_PPL+1:BIT_PPL] = ppl_q;
            end
            ADDR_IRQEN:   rd[NIRQ-1:0] = en_q;
            ADDR_PEND:    rd[NIRQ-1:0] = irq_lines_i;
            ADDR_VECTOR:  rd = vec_q;
            ADDR_EPC:     rd = epc_q;
            ADDR_SCRATCH: rd = scratch_q;
            ADDR_CAUSE: begin
                rd[XLEN-1]    = cause_irq_q;
                rd[CODEW-1:0] = cause_code_q;
            end
            default: rd = '0;
        endcase
    end

    always_comb begin
        unique case (csr_op_e'(csr_op_i))
            CSR_WRITE: nv = csr_wdata_i;
            CSR_SET:   nv = rd | csr_wdata_i;
            CSR_CLEAR: nv = rd & ~csr_wdata_i;
            default:   nv = rd;
        endcase
    end

    assign wr = csr_en_i && (csr_op_i != CSR_READ) && !trap_go_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gie_q        <= 1'b0;
            pie_q        <= 1'b0;
            ppl_q        <= PRIV_U;
            en_q         <= '0;
            vec_q        <= '0;
            epc_q        <= '0;
            scratch_q    <= '0;
            cause_irq_q  <= 1'b0;
            cause_code_q <= '0;
        end else if (trap_go_i) begin
            pie_q        <= gie_q;
            gie_q        <= 1'b0;
            ppl_q        <= cur_priv_i;
            epc_q        <= trap_pc_i & ALIGN_MASK;
            cause_irq_q  <= trap_irq_i;
            cause_code_q <= trap_code_i;
        end else if (ret_go_i) begin
            gie_q <= pie_q;
            pie_q <= 1'b1;
            ppl_q <= PRIV_U;
        end else if (wr) begin
            unique case (csr_addr_i)
                ADDR_STATUS: begin
                    gie_q <= nv[BIT_GIE];
                    pie_q <= nv[BIT_PIE];
                    if (nv[BIT_PPL+1:BIT_PPL] != 2'b10)
                        ppl_q <= priv_e'(nv[BIT_PPL+1:BIT_PPL]);
                end
                ADDR_IRQEN:   en_q      <= nv[NIRQ-1:0];
                ADDR_VECTOR:  vec_q     <= nv;
                ADDR_EPC:     epc_q     <= nv & ALIGN_MASK;
                ADDR_SCRATCH: scratch_q <= nv;
                ADDR_CAUSE: begin
                    cause_irq_q  <= nv[XLEN-1];
                    cause_code_q <= nv[CODEW-1:0];
                end
                default: ;
            endcase
        end
    end

    assign csr_rdata_o = rd;
    assign gie_o       = gie_q;
    assign ppl_o       = ppl_q;
    assign irq_en_o    = en_q;
    assign vec_o       = vec_q;
    assign epc_o       = epc_q;

    p_gie_saved_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_go_i |=> (!gie_q && pie_q == $past(gie_q)));
    p_level_saved_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_go_i |=> (ppl_q == $past(cur_priv_i)));
    p_cause_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_go_i |=> (cause_irq_q == $past(trap_irq_i)));
    p_ret_restore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_go_i |=> (pie_q && gie_q == $past(pie_q) && ppl_q == PRIV_U));
    p_no_write_on_trap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_go_i |=> ($stable(scratch_q) && $stable(en_q) && $stable(vec_q)));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NIRQ = 16,
    localparam int CODEW = $clog2(NIRQ)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             exc_req_i,
    input  logic [CODEW-1:0] exc_code_i,
    input  logic [XLEN-1:0]  trap_pc_i,
    input  logic [NIRQ-1:0]  irq_lines_i,
    input  logic             mret_i,
    input  logic             csr_en_i,
    input  logic [1:0]       csr_op_i,
    input  logic [11:0]      csr_addr_i,
    input  logic [XLEN-1:0]  csr_wdata_i,
    output logic [XLEN-1:0]  csr_rdata_o,
    output logic             trap_taken_o,
    output logic             ret_taken_o,
    output logic [XLEN-1:0]  redirect_pc_o,
    output logic [1:0]       priv_o
);
    priv_e            priv, ppl;
    logic             gie, irq_fire, trap_go, irq_go, ret_go;
    logic [CODEW-1:0] irq_code, trap_code;
    logic [NIRQ-1:0]  irq_en;
    logic [XLEN-1:0]  vec, epc, base;

    trap_irq_arb #(.NIRQ(NIRQ), .CODEW(CODEW)) arb_i (
        .pend_i (irq_lines_i),
        .en_i   (irq_en),
        .gate_i ((priv != PRIV_M) || gie),
        .fire_o (irq_fire),
        .code_o (irq_code)
    );

    assign trap_go   = exc_req_i || irq_fire;
    assign irq_go    = irq_fire && !exc_req_i;
    assign trap_code = exc_req_i ? exc_code_i : irq_code;
    assign ret_go    = mret_i && !trap_go && (priv == PRIV_M);

    trap_priv_fsm fsm_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .trap_go_i (trap_go),
        .ret_go_i  (ret_go),
        .ret_lvl_i (ppl),
        .priv_o    (priv)
    );

    trap_csr_regs #(.XLEN(XLEN), .NIRQ(NIRQ), .CODEW(CODEW)) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .csr_en_i    (csr_en_i),
        .csr_op_i    (csr_op_i),
        .csr_addr_i  (csr_addr_i),
        .csr_wdata_i (csr_wdata_i),
        .csr_rdata_o (csr_rdata_o),
        .trap_go_i   (trap_go),
        .trap_irq_i  (irq_go),
        .trap_code_i (trap_code),
        .trap_pc_i   (trap_pc_i),
        .ret_go_i    (ret_go),
        .cur_priv_i  (priv),
        .irq_lines_i (irq_lines_i),
        .gie_o       (gie),
        .ppl_o       (ppl),
        .irq_en_o    (irq_en),
        .vec_o       (vec),
        .epc_o       (epc)
    );

    assign base = {vec[XLEN-1:2], 2'b00};

    always_comb begin
        if (trap_go) begin
            if (irq_go && (vec[1:0] != 2'b00))
                redirect_pc_o = base + {{(XLEN-CODEW-2){1'b0}}, irq_code, 2'b00};
            else
                redirect_pc_o = base;
        end else begin
            redirect_pc_o = epc;
        end
    end

    assign trap_taken_o = trap_go;
    assign ret_taken_o  = ret_go;
    assign priv_o       = priv;

    p_flags_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(trap_taken_o && ret_taken_o));
    p_exc_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i && trap_taken_o) |-> (redirect_pc_o == base));
endmodule

// File: tb/trap_ctrl_tb.sv
module trap_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [3:0]  exc_code = '0;
    logic [31:0] trap_pc = '0;
    logic [15:0] lines = '0;
    logic        mret = 1'b0;
    logic        csr_en = 1'b0;
    logic [1:0]  csr_op = '0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        trap_taken, ret_taken;
    logic [31:0] redirect_pc;
    logic [1:0]  priv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trap_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .exc_code_i(exc_code),
        .trap_pc_i(trap_pc), .irq_lines_i(lines), .mret_i(mret), .csr_en_i(csr_en),
        .csr_op_i(csr_op), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
        .csr_rdata_o(csr_rdata), .trap_taken_o(trap_taken), .ret_taken_o(ret_taken),
        .redirect_pc_o(redirect_pc), .priv_o(priv)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic csr_do(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_en = 1'b1; csr_op = op; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_en = 1'b0; csr_op = 2'b00;
    endtask

    task automatic csr_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_en = 1'b1; csr_op = 2'b00; csr_addr = a;
        #1 check(tag, csr_rdata, exp);
        csr_en = 1'b0;
    endtask

    task automatic do_ret(input logic [31:0] exp_pc, input string tag);
        @(negedge clk);
        mret = 1'b1;
        #1 check({tag, " ret flag"}, 32'(ret_taken), 32'd1);
        check({tag, " ret pc"}, redirect_pc, exp_pc);
        @(negedge clk);
        mret = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 level", 32'(priv), 32'h3);
        csr_rd(12'h300, 32'h0, "R1 status");
        csr_rd(12'h304, 32'h0, "R1 enable");
        csr_rd(12'h305, 32'h0, "R1 vector");
        csr_rd(12'h340, 32'h0, "R1 scratch");
        csr_rd(12'h341, 32'h0, "R1 epc");
        csr_rd(12'h342, 32'h0, "R1 cause");
    endtask

    task automatic t_csr_ops;
        csr_do(2'b01, 12'h340, 32'hA5A5_0000);
        @(negedge clk);
        csr_en = 1'b1; csr_op = 2'b10; csr_addr = 12'h340; csr_wdata = 32'h0000_000F;
        #1 check("R2 old value during set", csr_rdata, 32'hA5A5_0000);
        @(negedge clk);
        csr_en = 1'b0;
        csr_rd(12'h340, 32'hA5A5_000F, "R2 set");
        csr_do(2'b11, 12'h340, 32'hA500_0000);
        csr_rd(12'h340, 32'h00A5_000F, "R2 clear");
        csr_do(2'b01, 12'h7C0, 32'hFFFF_FFFF);
        csr_rd(12'h7C0, 32'h0, "R2 unknown address");
    endtask

    task automatic t_field_rules;
        csr_do(2'b01, 12'h344, 32'h0000_FFFF);
        csr_rd(12'h344, 32'h0, "R10 pending ignores write");
        csr_do(2'b01, 12'h300, 32'h0000_0800);
        csr_do(2'b01, 12'h300, 32'h0000_1000);
        csr_rd(12'h300, 32'h0000_0800, "R10 reserved level kept");
        csr_do(2'b01, 12'h341, 32'h0000_0123);
        csr_rd(12'h341, 32'h0000_0120, "R3 epc aligned");
    endtask

    task automatic t_ret_to_s;
        csr_do(2'b01, 12'h305, 32'h0000_1000);
        do_ret(32'h0000_0120, "R8");
        check("R8 level after return", 32'(priv), 32'h1);
        csr_rd(12'h300, 32'h0000_0080, "R8 status after return");
        @(negedge clk);
        mret = 1'b1;
        #1 check("R8 return ignored below machine", 32'(ret_taken), 32'd0);
        @(negedge clk);
        mret = 1'b0;
        check("R8 level unchanged", 32'(priv), 32'h1);
    endtask

    task automatic t_exc(input logic [3:0] code, input logic [31:0] pc,
                         input logic [31:0] exp_pc, input string tag);
        @(negedge clk);
        exc_req = 1'b1; exc_code = code; trap_pc = pc;
        #1 check({tag, " trap flag"}, 32'(trap_taken), 32'd1);
        check({tag, " redirect"}, redirect_pc, exp_pc);
        @(negedge clk);
        exc_req = 1'b0;
    endtask

    task automatic t_exceptions;
        t_exc(4'd9, 32'h0000_0207, 32'h0000_1000, "R7 S exception");
        check("R3 level machine", 32'(priv), 32'h3);
        csr_rd(12'h341, 32'h0000_0204, "R3 epc");
        csr_rd(12'h342, 32'h0000_0009, "R4 exception cause");
        csr_rd(12'h300, 32'h0000_0800, "R3 status saved S");
        csr_do(2'b01, 12'h300, 32'h0);
        csr_do(2'b01, 12'h341, 32'h0000_0300);
        do_ret(32'h0000_0300, "R8 to user");
        check("R8 user level", 32'(priv), 32'h0);
        t_exc(4'd8, 32'h0000_0300, 32'h0000_1000, "R3 user ecall");
        csr_rd(12'h342, 32'h0000_0008, "R4 ecall cause");
        csr_rd(12'h300, 32'h0000_0000, "R3 status saved U");
    endtask

    task automatic t_int_machine;
        csr_do(2'b01, 12'h304, 32'h0000_0080);
        @(negedge clk);
        lines = 16'h0080; trap_pc = 32'h0000_0400;
        #1 check("R5 masked by global enable", 32'(trap_taken), 32'd0);
        csr_en = 1'b1; csr_op = 2'b00; csr_addr = 12'h344;
        #1 check("R10 pending mirrors lines", csr_rdata, 32'h0000_0080);
        csr_en = 1'b0;
        @(negedge clk);
        lines = '0;
        csr_do(2'b10, 12'h300, 32'h0000_0008);
        @(negedge clk);
        lines = 16'h0080;
        #1 check("R5 machine interrupt taken", 32'(trap_taken), 32'd1);
        check("R7 direct interrupt", redirect_pc, 32'h0000_1000);
        @(negedge clk);
        lines = '0;
        csr_rd(12'h342, 32'h8000_0007, "R4 interrupt cause");
        csr_rd(12'h300, 32'h0000_1880, "R3 status after interrupt");
        csr_rd(12'h341, 32'h0000_0400, "R3 epc interrupt");
        csr_do(2'b10, 12'h300, 32'h0000_0008);
        @(negedge clk);
        lines = 16'h0020;
        #1 check("R5 line without mask bit", 32'(trap_taken), 32'd0);
        @(negedge clk);
        lines = '0;
    endtask

    task automatic t_int_user;
        csr_do(2'b01, 12'h305, 32'h0000_2001);
        csr_do(2'b01, 12'h300, 32'h0);
        csr_do(2'b01, 12'h341, 32'h0000_0500);
        do_ret(32'h0000_0500, "R8 user again");
        @(negedge clk);
        lines = 16'h0080; trap_pc = 32'h0000_0504;
        #1 check("R5 user ignores global enable", 32'(trap_taken), 32'd1);
        check("R7 vectored interrupt", redirect_pc, 32'h0000_201C);
        @(negedge clk);
        lines = '0;
        check("R3 back to machine", 32'(priv), 32'h3);
        csr_rd(12'h300, 32'h0, "R3 status from user");
    endtask

    task automatic t_collision;
        csr_do(2'b01, 12'h304, 32'h0000_0088);
        csr_do(2'b10, 12'h300, 32'h0000_0008);
        @(negedge clk);
        lines = 16'h0088; exc_req = 1'b1; exc_code = 4'd2; trap_pc = 32'h0000_0600;
        mret = 1'b1; csr_en = 1'b1; csr_op = 2'b01; csr_addr = 12'h340;
        csr_wdata = 32'h0000_DEAD;
        #1 check("R9 trap flag", 32'(trap_taken), 32'd1);
        check("R9 return cancelled", 32'(ret_taken), 32'd0);
        check("R9 exception to base", redirect_pc, 32'h0000_2000);
        @(negedge clk);
        exc_req = 1'b0; mret = 1'b0; csr_en = 1'b0;
        check("R9 level stays machine", 32'(priv), 32'h3);
        csr_rd(12'h340, 32'h00A5_000F, "R9 write cancelled");
        csr_rd(12'h342, 32'h0000_0002, "R9 exception cause wins");
        csr_rd(12'h341, 32'h0000_0600, "R9 epc from trap");
        csr_do(2'b10, 12'h300, 32'h0000_0008);
        #1 check("R6 highest line taken", 32'(trap_taken), 32'd1);
        check("R6 highest line offset", redirect_pc, 32'h0000_201C);
        @(negedge clk);
        lines = '0;
        csr_rd(12'h342, 32'h8000_0007, "R6 cause line 7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_csr_ops();
        t_field_rules();
        t_ret_to_s();
        t_exceptions();
        t_int_machine();
        t_int_user();
        t_collision();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule